// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational two's-complement/unsigned adder. It takes two 16-bit operands and a carry-in, and returns a 16-bit sum and a carry-out. The operand is cut into four 4-bit groups.

Inside each group, every bit forms a generate term (both operand bits set) and a propagate term (operand bits differ). The group turns those terms into its own internal carries and sum bits. It also reports one group-level generate and one group-level propagate.

A separate second-level lookahead unit takes the four group terms and the external carry-in. From them it forms the carry into each group and the final carry-out as flat sum-of-products expressions. No carry ripples from one group into the next. The block sits between operand registers of a datapath and has no clock or state of its own.

Top module: `cla_adder_top`

## Requirements
- R1: For every operand pair and carry-in, `{co, sum}` equals the 17-bit arithmetic result `op_x + op_y + ci`.
- R2: When the operands are bitwise complements (every bit propagates), the carry-in passes through the whole width: `sum` is 16'hFFFF and `co` is 0 for `ci`=0, and `sum` is 16'h0000 and `co` is 1 for `ci`=1.
- R3: When both operands are zero (every bit kills), `co` is 0 and `sum` equals the zero-extended `ci`, whatever the carry-in.
- R4: When both operands are 16'hFFFF (every bit generates), `co` is 1 and `sum` is 16'hFFFE with bit 0 equal to `ci`.
- R5: A carry produced inside a low group reaches the next group. For example, 16'h000F + 16'h0001 gives 16'h0010 with `co`=0.
- R6: A carry generated in the lowest group, with every higher group fully propagating, reaches `co`. 16'hFFF8 + 16'h0008 gives `sum`=16'h0000 and `co`=1.
- R7: Sum bit j depends only on operand bits 0..j and `ci`. Changing only the upper 8 bits of both operands leaves `sum[7:0]` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 16 | First addend |
| op_y | input | 16 | Second addend |
| ci | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| co | output | 1 | Carry out of bit 15 |

## Verification
Two functions can both drive the carry into a group in the same evaluation: the external carry-in rippling through propagating groups, and a generate produced inside a lower group. The bench provokes this by pairing group-generate operands with `ci`=1. It also applies the all-generate and all-propagate patterns with both carry-in values. Every result is judged against a 17-bit behavioural sum computed in the bench, so a doubled or lost carry shows up as a wrong `co` or a wrong sum bit.

// File: rtl/cla_pkg.sv
// Package: shared sizes and the flat lookahead expression used at both levels.
// Assumes widths passed to the function are at most LA_MAXW bits.
package cla_pkg;
    localparam int LA_MAXW = 32;

    // Carry into position idx, written as a flat sum of products of the
    // generate/propagate vectors and the incoming carry (no recurrence).
    function automatic logic la_carry(input logic [LA_MAXW-1:0] gen,
                                      input logic [LA_MAXW-1:0] prop,
                                      input logic cin,
                                      input int idx);
        logic res;
        logic term;
        res = cin;
        for (int m = 0; m < idx; m++) res = res & prop[m];
        for (int k = 0; k < idx; k++) begin
            term = gen[k];
            for (int m = k + 1; m < idx; m++) term = term & prop[m];
            res = res | term;
        end
        return res;
    endfunction
endpackage

// File: rtl/cla_pg_bits.sv
// Module: per-bit generate and propagate terms.
// Assumes nothing beyond equal-width operands.
module cla_pg_bits #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] g,
    output logic [W-1:0] p
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: generate when both bits set, propagate when they differ.
        assign g[i] = a[i] & b[i];
        assign p[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/cla_group.sv
// Module: one lookahead group. Computes its internal carries, sum bits,
// and the group generate/propagate for the second level.
// Assumes GW <= cla_pkg::LA_MAXW.
module cla_group
    import cla_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] g,
    input  logic [GW-1:0] p,
    input  logic          cin,
    output logic [GW-1:0] s,
    output logic          grp_g,
    output logic          grp_p
);
    logic [LA_MAXW-1:0] g_ext;
    logic [LA_MAXW-1:0] p_ext;
    logic [GW-1:0]      c;

    // Purpose: zero-extend the terms for the shared lookahead function.
    always_comb begin
        g_ext = '0;
        p_ext = '0;
        g_ext[GW-1:0] = g;
        p_ext[GW-1:0] = p;
    end

    // Purpose: flat carry into each bit of the group, then the sum bits.
    always_comb begin
        for (int j = 0; j < GW; j++) c[j] = la_carry(g_ext, p_ext, cin, j);
        s = p ^ c;
    end

    // Purpose: group-level terms for the second lookahead level.
    always_comb begin
        grp_p = &p;
        grp_g = la_carry(g_ext, p_ext, 1'b0, GW);
    end

    // Purpose: a fully propagating group cannot also generate.
    always_comb begin
        // R6
        grp_gp_excl_chk: assert (!(grp_g && grp_p))
            else $error("group generate and propagate both set");
    end
endmodule

// File: rtl/cla_lookahead.sv
// Module: second-level lookahead unit. Forms the carry into each group and
// the final carry-out from the group terms and the external carry-in.
// Assumes NG <= cla_pkg::LA_MAXW.
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int NG = 4
) (
    input  logic [NG-1:0] gg,
    input  logic [NG-1:0] gp,
    input  logic          cin,
    output logic [NG:0]   cgrp
);
    logic [LA_MAXW-1:0] gg_ext;
    logic [LA_MAXW-1:0] gp_ext;

    // Purpose: flat carry into every group boundary, including the top.
    always_comb begin
        gg_ext = '0;
        gp_ext = '0;
        gg_ext[NG-1:0] = gg;
        gp_ext[NG-1:0] = gp;
        for (int j = 0; j <= NG; j++) cgrp[j] = la_carry(gg_ext, gp_ext, cin, j);
    end

    // Purpose: each flat carry obeys the kill/propagate/generate recurrence.
    always_comb begin
        for (int j = 0; j < NG; j++) begin
            // R4
            grp_generate_chk: assert (!gg[j] || cgrp[j+1])
                else $error("group %0d generated but no carry out", j);
            // R2
            grp_propagate_chk: assert (!gp[j] || (cgrp[j+1] == cgrp[j]))
                else $error("group %0d propagate mismatch", j);
            // R3
            grp_kill_chk: assert (gg[j] || gp[j] || !cgrp[j+1])
                else $error("group %0d killed but carry out", j);
        end
    end
endmodule

// File: rtl/cla_adder_top.sv
// Module: two-level carry-lookahead adder top. Bit terms feed NG groups;
// group terms feed the second-level unit, whose carries feed back into the groups.
// Assumes W is a multiple of GW.
module cla_adder_top #(
    parameter int W  = 16,
    parameter int GW = 4
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    localparam int NG = W / GW;

    logic [W-1:0]  bg;
    logic [W-1:0]  bp;
    logic [NG-1:0] gg;
    logic [NG-1:0] gp;
    logic [NG:0]   cgrp;

    cla_pg_bits #(.W(W)) u_pg (
        .a(op_x), .b(op_y), .g(bg), .p(bp)
    );

    for (genvar k = 0; k < NG; k++) begin : g_grp
        cla_group #(.GW(GW)) u_grp (
            .g    (bg[k*GW +: GW]),
            .p    (bp[k*GW +: GW]),
            .cin  (cgrp[k]),
            .s    (sum[k*GW +: GW]),
            .grp_g(gg[k]),
            .grp_p(gp[k])
        );
    end

    cla_lookahead #(.NG(NG)) u_la (
        .gg(gg), .gp(gp), .cin(ci), .cgrp(cgrp)
    );

    // Purpose: carry-out is the carry past the top group.
    assign co = cgrp[NG];

    // Purpose: whole-adder result against arithmetic addition.
    always_comb begin
        // R1
        add_result_chk: assert ({co, sum} == ({1'b0, op_x} + {1'b0, op_y} + {{W{1'b0}}, ci}))
            else $error("adder result mismatch");
    end
endmodule

// File: tb/sim_cla_adder_top.sv
module sim_cla_adder_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_x = '0;
    logic [15:0] op_y = '0;
    logic        ci = 1'b0;
    logic [15:0] sum;
    logic        co;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    cla_adder_top u0 (.op_x(op_x), .op_y(op_y), .ci(ci), .sum(sum), .co(co));

    // Apply one vector on the falling edge, sample after the next rising edge.
    task automatic apply_check(input string tag, input logic [15:0] x,
                               input logic [15:0] y, input logic c);
        logic [16:0] exp_v;
        @(negedge clk);
        op_x = x; op_y = y; ci = c;
        exp_v = {1'b0, x} + {1'b0, y} + {16'b0, c};
        @(posedge clk); #1;
        n_run++;
        if ({co, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: %h+%h+%0d got co=%0d sum=%h exp co=%0d sum=%h",
                     tag, x, y, c, co, sum, exp_v[16], exp_v[15:0]);
        end
    endtask

    initial begin
        logic [7:0] low_ref;
        logic [15:0] rx, ry;
        logic rc;
        repeat (3) @(posedge clk);
        #1;
        // R3 reset state: zero operands, zero carry give zero result
        n_run++;
        if ({co, sum} !== 17'h0) begin
            n_fail++;
            $display("FAIL R3 reset: got %h exp 0", {co, sum});
        end
        rst_n = 1'b1;
        apply_check("R3 kill ci0", 16'h0000, 16'h0000, 1'b0);
        apply_check("R3 kill ci1", 16'h0000, 16'h0000, 1'b1);
        apply_check("R2 propagate ci0", 16'hA5C3, 16'h5A3C, 1'b0);
        apply_check("R2 propagate ci1", 16'hA5C3, 16'h5A3C, 1'b1);
        apply_check("R2 propagate all ci1", 16'hFFFF, 16'h0000, 1'b1);
        apply_check("R4 generate ci0", 16'hFFFF, 16'hFFFF, 1'b0);
        apply_check("R4 generate ci1", 16'hFFFF, 16'hFFFF, 1'b1);
        apply_check("R5 group cross", 16'h000F, 16'h0001, 1'b0);
        apply_check("R5 group cross mid", 16'h00FF, 16'h0001, 1'b0);
        apply_check("R5 group cross top", 16'h0FFF, 16'h0001, 1'b0);
        apply_check("R6 low gen chain", 16'hFFF8, 16'h0008, 1'b0);
        apply_check("R6 gen plus ci", 16'hFFF8, 16'h0008, 1'b1);
        apply_check("R6 mid gen plus ci", 16'hF8FF, 16'h0800, 1'b1);
        apply_check("R1 max signed", 16'h7FFF, 16'h0001, 1'b0);
        apply_check("R1 min signed", 16'h8000, 16'h8000, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            rx = 16'($urandom); ry = 16'($urandom); rc = 1'($urandom);
            apply_check("R1 random", rx, ry, rc);
        end
        // R7: upper operand bits do not reach the low sum byte
        for (int i = 0; i < 40; i++) begin
            rx = 16'($urandom); ry = 16'($urandom); rc = 1'($urandom);
            apply_check("R7 base", rx, ry, rc);
            low_ref = sum[7:0];
            apply_check("R7 upper changed", {~rx[15:8], rx[7:0]}, {8'($urandom), ry[7:0]}, rc);
            n_run++;
            if (sum[7:0] !== low_ref) begin
                n_fail++;
                $display("FAIL R7: low byte got %h exp %h", sum[7:0], low_ref);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule